// File: doc/BRIEF.md
# Instruction Look-Ahead Fetch Requester

This block is the CPU side of a two-deep instruction pipeline. It holds a current-instruction register that the execution logic works from and a next-instruction register that refills over a shared module bus while the current instruction runs. When the microcode decoder asserts the advance strobe, the block does three things. It moves the prefetched word into the current register. It captures the program-counter value as the fetch address. It raises a low-priority bus request.

A low-priority request may transmit only when the bus grant and the destination module's ready signal are both seen in the same cycle. At that point the block drives the captured address, a read command and its own source tag for exactly one cycle. It then waits for a returned word that carries its tag. That word loads the next-instruction register and marks it valid. If the decoder asserts the advance strobe while a fetch is still outstanding, the block stalls the strobe until the word returns. The decoder keeps the strobe high until the stall output drops.

Top module: `ilk_fetch_top`

## Requirements
- R1: After synchronous active-low reset, the following are all zero: bus_req_o, bus_send_o, bus_addr_o, nir_valid_o, stall_o and cir_o.
- R2: An accepted advance (adv_i high, stall_o low at a clock edge) copies the prefetched word into cir_o, raises bus_req_o and clears nir_valid_o, all visible after that edge.
- R3: bus_req_o stays high until a cycle in which bus_grant_i and dst_rdy_i are both high. A grant without destination-ready sends nothing.
- R4: The edge that sees grant and ready together drops bus_req_o and raises bus_send_o for exactly one cycle. During that cycle bus_addr_o carries the captured address, bus_cmd_o is 0 (read; 1 would mean write) and bus_src_o equals the SRC_ID parameter.
- R5: The fetch address is the pc_i value at the accepting edge. Later changes to pc_i do not alter it.
- R6: A return beat (ret_valid_i high) whose ret_tag_i equals SRC_ID, arriving while a fetch is outstanding, loads ret_data_i into the next-instruction register and sets nir_valid_o after that edge.
- R7: A return beat with any other tag leaves nir_valid_o clear and the next-instruction register unchanged.
- R8: While a request or a fetch is outstanding, adv_i drives stall_o high in the same cycle and cir_o does not change.
- R9: The word loaded by a return appears on cir_o after the next accepted advance, giving one instruction of look-ahead.
- R10: bus_addr_o is zero in every cycle in which bus_send_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_i | input | 1 | Advance strobe from the microcode decoder, held until not stalled |
| pc_i | input | AW | Program-counter address of the instruction to prefetch |
| stall_o | output | 1 | Advance cannot be taken this cycle |
| cir_o | output | DW | Current instruction being executed |
| nir_valid_o | output | 1 | Next-instruction register holds a returned word |
| bus_req_o | output | 1 | Low-priority bus request |
| bus_grant_i | input | 1 | Bus grant |
| dst_rdy_i | input | 1 | Destination module ready |
| bus_send_o | output | 1 | Address/command phase valid |
| bus_addr_o | output | AW | Fetch address, zero outside the send cycle |
| bus_cmd_o | output | 1 | Command: 0 read, 1 write |
| bus_src_o | output | SRC_W | Source tag of this module |
| ret_valid_i | input | 1 | Return data beat valid |
| ret_tag_i | input | SRC_W | Destination tag of the return beat |
| ret_data_i | input | DW | Returned instruction word |

## Verification
The bench builds the block with its defaults: 16-bit address and data, a 3-bit tag and SRC_ID of 5. With these values the bench can use random full-width addresses and data words, and it can inject stray return beats under all seven foreign tags. Grants arrive at random, with and without destination-ready, so that the hold-until-ready rule is exercised with gaps of several cycles. Advance strobes are raised in the middle of a fetch to drive the stall path. The first advance after reset covers the empty-pipeline start.

// File: rtl/ilk_pkg.sv
// Package: shared bus command encoding for the look-ahead fetch requester.
// Assumes a one-bit command field on the module bus.
package ilk_pkg;

    typedef enum logic {
        CMD_READ  = 1'b0,
        CMD_WRITE = 1'b1
    } bus_cmd_e;

endpackage

// File: rtl/ilk_ret_filt.sv
// Module: ilk_ret_filt
// Accepts a return beat only when its tag matches this module's source code
// and a fetch is outstanding. Purely combinational.
// Assumes the tag is compared on the same cycle as ret_valid_i.
module ilk_ret_filt #(
    parameter int SRC_W  = 3,
    parameter int SRC_ID = 5
) (
    input  logic             ret_valid_i,
    input  logic [SRC_W-1:0] ret_tag_i,
    input  logic             await_i,
    output logic             hit_o
);
    localparam logic [SRC_W-1:0] MY_TAG = SRC_W'(SRC_ID);

    // Qualify the beat by tag and by an outstanding fetch.
    always_comb begin
        hit_o = ret_valid_i && (ret_tag_i == MY_TAG) && await_i;
    end
endmodule

// File: rtl/ilk_req_ctl.sv
// Module: ilk_req_ctl
// Owns the low-request flop, the address register, the one-cycle send
// phase and the outstanding-fetch flag.
// Assumes fire_i is only asserted while busy_o is low.
module ilk_req_ctl #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic [AW-1:0] pc_i,
    input  logic          grant_i,
    input  logic          rdy_i,
    input  logic          ret_hit_i,
    output logic          req_o,
    output logic          send_o,
    output logic [AW-1:0] addr_o,
    output logic          await_o,
    output logic          busy_o
);
    logic          req_q;
    logic          send_q;
    logic          await_q;
    logic [AW-1:0] addr_q;
    logic          go;

    // A low request transmits only with grant and destination ready together.
    always_comb begin
        go = req_q && grant_i && rdy_i;
    end

    // Capture the fetch address when an advance is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (fire_i) addr_q <= pc_i;
    end

    // Low-request flop: set on advance, cleared when the send is launched.
    always_ff @(posedge clk) begin
        if (!rst_n)      req_q <= 1'b0;
        else if (fire_i) req_q <= 1'b1;
        else if (go)     req_q <= 1'b0;
    end

    // Send phase lasts exactly one cycle after grant and ready.
    always_ff @(posedge clk) begin
        if (!rst_n) send_q <= 1'b0;
        else        send_q <= go;
    end

    // Outstanding flag: set with the send, cleared by a matching return.
    always_ff @(posedge clk) begin
        if (!rst_n)         await_q <= 1'b0;
        else if (go)        await_q <= 1'b1;
        else if (ret_hit_i) await_q <= 1'b0;
    end

    // Drive the bus outputs; the address is zeroed outside the send cycle.
    always_comb begin
        req_o   = req_q;
        send_o  = send_q;
        addr_o  = send_q ? addr_q : '0;
        await_o = await_q;
        busy_o  = req_q || await_q;
    end
endmodule

// File: rtl/ilk_iregs.sv
// Module: ilk_iregs
// Holds the next- and current-instruction registers and the look-ahead
// valid flag. Assumes fire_i and ret_hit_i never coincide (the return
// path only fires while a fetch is outstanding, which blocks fire_i).
module ilk_iregs #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic          ret_hit_i,
    input  logic [DW-1:0] ret_data_i,
    output logic [DW-1:0] cir_o,
    output logic          nir_valid_o
);
    logic [DW-1:0] nir_q;
    logic [DW-1:0] cir_q;
    logic          nv_q;

    // Refill the next-instruction register from a matching return.
    always_ff @(posedge clk) begin
        if (!rst_n)         nir_q <= '0;
        else if (ret_hit_i) nir_q <= ret_data_i;
    end

    // Move the prefetched word into execution on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      cir_q <= '0;
        else if (fire_i) cir_q <= nir_q;
    end

    // Valid flag: cleared by an advance, set by a loaded return.
    always_ff @(posedge clk) begin
        if (!rst_n)         nv_q <= 1'b0;
        else if (fire_i)    nv_q <= 1'b0;
        else if (ret_hit_i) nv_q <= 1'b1;
    end

    // Present the register contents.
    always_comb begin
        cir_o       = cir_q;
        nir_valid_o = nv_q;
    end
endmodule

// File: rtl/ilk_fetch_top.sv
// Module: ilk_fetch_top
// Instruction look-ahead fetch requester: advances the current/next
// instruction pair and refills the next word over the module bus with a
// low-priority read. Assumes adv_i is held by the decoder until stall_o
// is low. After reset the first advance is accepted with an empty pipeline.
module ilk_fetch_top #(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int SRC_W  = 3,
    parameter int SRC_ID = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [AW-1:0]    pc_i,
    output logic             stall_o,
    output logic [DW-1:0]    cir_o,
    output logic             nir_valid_o,
    output logic             bus_req_o,
    input  logic             bus_grant_i,
    input  logic             dst_rdy_i,
    output logic             bus_send_o,
    output logic [AW-1:0]    bus_addr_o,
    output logic             bus_cmd_o,
    output logic [SRC_W-1:0] bus_src_o,
    input  logic             ret_valid_i,
    input  logic [SRC_W-1:0] ret_tag_i,
    input  logic [DW-1:0]    ret_data_i
);
    import ilk_pkg::*;

    localparam logic [SRC_W-1:0] MY_TAG = SRC_W'(SRC_ID);

    logic fire;
    logic busy;
    logic await_w;
    logic ret_hit;

    // Take an advance only when no request or fetch is in flight.
    always_comb begin
        fire    = adv_i && !busy;
        stall_o = adv_i && busy;
    end

    // Fixed fields of the address phase: read command and own source tag.
    always_comb begin
        bus_cmd_o = bus_send_o ? logic'(CMD_READ) : 1'b0;
        bus_src_o = MY_TAG;
    end

    ilk_req_ctl #(.AW(AW)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire),
        .pc_i      (pc_i),
        .grant_i   (bus_grant_i),
        .rdy_i     (dst_rdy_i),
        .ret_hit_i (ret_hit),
        .req_o     (bus_req_o),
        .send_o    (bus_send_o),
        .addr_o    (bus_addr_o),
        .await_o   (await_w),
        .busy_o    (busy)
    );

    ilk_ret_filt #(.SRC_W(SRC_W), .SRC_ID(SRC_ID)) u_filt (
        .ret_valid_i (ret_valid_i),
        .ret_tag_i   (ret_tag_i),
        .await_i     (await_w),
        .hit_o       (ret_hit)
    );

    ilk_iregs #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (fire),
        .ret_hit_i   (ret_hit),
        .ret_data_i  (ret_data_i),
        .cir_o       (cir_o),
        .nir_valid_o (nir_valid_o)
    );
endmodule

// File: rtl/ilk_fetch_chk.sv
// Module: ilk_fetch_chk
// Protocol checker attached to ilk_fetch_top by bind; observes ports only.
module ilk_fetch_chk #(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int SRC_W  = 3,
    parameter int SRC_ID = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv_i,
    input logic [AW-1:0]    pc_i,
    input logic             stall_o,
    input logic [DW-1:0]    cir_o,
    input logic             nir_valid_o,
    input logic             bus_req_o,
    input logic             bus_grant_i,
    input logic             dst_rdy_i,
    input logic             bus_send_o,
    input logic [AW-1:0]    bus_addr_o,
    input logic             bus_cmd_o,
    input logic [SRC_W-1:0] bus_src_o,
    input logic             ret_valid_i,
    input logic [SRC_W-1:0] ret_tag_i,
    input logic [DW-1:0]    ret_data_i
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !(bus_grant_i && dst_rdy_i)) |=> bus_req_o); // R3

    AST_SEND_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_send_o) |-> $past(bus_req_o && bus_grant_i && dst_rdy_i)); // R3

    AST_SEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_send_o |=> !bus_send_o); // R4

    AST_SEND_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_send_o |-> (bus_cmd_o == 1'b0 && bus_src_o == SRC_W'(SRC_ID) && !bus_req_o)); // R4

    AST_ADDR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_send_o |-> (bus_addr_o == '0)); // R10

    AST_CIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv_i && !stall_o) |=> $stable(cir_o)); // R8

    AST_STALL_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> !nir_valid_o); // R8

    AST_ADV_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !stall_o) |=> (!nir_valid_o && bus_req_o)); // R2
endmodule

bind ilk_fetch_top ilk_fetch_chk #(.AW(AW), .DW(DW), .SRC_W(SRC_W), .SRC_ID(SRC_ID)) u_chk (.*);

// File: tb/tb_ilk_fetch_top.sv
// Bench: seeded random fetch sequences plus directed corner cases.
module tb_ilk_fetch_top;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int SRC_W = 3;
    localparam int SRC_ID = 5;
    localparam logic [SRC_W-1:0] MY = SRC_W'(SRC_ID);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv_i = 1'b0;
    logic [AW-1:0] pc_i = '0;
    logic stall_o;
    logic [DW-1:0] cir_o;
    logic nir_valid_o;
    logic bus_req_o;
    logic bus_grant_i = 1'b0;
    logic dst_rdy_i = 1'b0;
    logic bus_send_o;
    logic [AW-1:0] bus_addr_o;
    logic bus_cmd_o;
    logic [SRC_W-1:0] bus_src_o;
    logic ret_valid_i = 1'b0;
    logic [SRC_W-1:0] ret_tag_i = '0;
    logic [DW-1:0] ret_data_i = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [DW-1:0] exp_nir = '0;

    ilk_fetch_top #(.AW(AW), .DW(DW), .SRC_W(SRC_W), .SRC_ID(SRC_ID)) dut (.*);

    always #5 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total + 1, bad);
            $finish;
        end
    end

    function automatic logic tag_accepted(input logic [SRC_W-1:0] t);
        return t == MY;
    endfunction

    function automatic logic [SRC_W-1:0] foreign_tag(input logic [SRC_W-1:0] seed);
        return (seed == MY) ? MY + 1'b1 : seed;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One complete fetch: advance, arbitration, send, optional stray, return.
    task automatic fetch(input logic [AW-1:0] pc, input logic [DW-1:0] data,
                         input int nogo, input bit stray, input bit early_adv);
        logic [DW-1:0] prev_cir;
        adv_i = 1'b1;
        pc_i = pc;
        #1;
        chk("R8 idle advance not stalled", stall_o, 0);
        tick();
        adv_i = 1'b0;
        chk("R2 cir gets prefetched word", cir_o, exp_nir);
        chk("R9 look-ahead word executed", cir_o, exp_nir);
        chk("R2 request raised", bus_req_o, 1);
        chk("R2 valid cleared", nir_valid_o, 0);
        pc_i = AW'($urandom);
        prev_cir = cir_o;
        for (int i = 0; i < nogo; i++) begin
            bus_grant_i = 1'($urandom);
            dst_rdy_i = !bus_grant_i;
            if (early_adv) begin
                adv_i = 1'b1;
                #1;
                chk("R8 stall during fetch", stall_o, 1);
            end
            tick();
            chk("R3 request held", bus_req_o, 1);
            chk("R3 no send without both", bus_send_o, 0);
            chk("R8 cir unchanged", cir_o, prev_cir);
            chk("R10 address zero idle", bus_addr_o, 0);
        end
        adv_i = 1'b0;
        bus_grant_i = 1'b1;
        dst_rdy_i = 1'b1;
        tick();
        bus_grant_i = 1'b0;
        dst_rdy_i = 1'b0;
        chk("R4 send pulse", bus_send_o, 1);
        chk("R5 address is pc at accept", bus_addr_o, pc);
        chk("R4 read command", bus_cmd_o, 0);
        chk("R4 source tag", bus_src_o, MY);
        chk("R4 request dropped", bus_req_o, 0);
        tick();
        chk("R4 send one cycle", bus_send_o, 0);
        chk("R10 address zero after send", bus_addr_o, 0);
        if (stray) begin
            ret_valid_i = 1'b1;
            ret_tag_i = foreign_tag(SRC_W'($urandom));
            ret_data_i = ~data;
            tick();
            ret_valid_i = 1'b0;
            chk("R7 foreign tag ignored", nir_valid_o, tag_accepted(ret_tag_i));
        end
        ret_valid_i = 1'b1;
        ret_tag_i = MY;
        ret_data_i = data;
        tick();
        ret_valid_i = 1'b0;
        chk("R6 valid after matching return", nir_valid_o, 1);
        exp_nir = data;
    endtask

    initial begin
        int junk;
        junk = $urandom(32'h1D2C3B);
        repeat (3) tick();
        chk("R1 req reset", bus_req_o, 0);
        chk("R1 send reset", bus_send_o, 0);
        chk("R1 addr reset", bus_addr_o, 0);
        chk("R1 valid reset", nir_valid_o, 0);
        chk("R1 cir reset", cir_o, 0);
        chk("R1 stall reset", stall_o, 0);
        rst_n = 1'b1;
        tick();
        // Directed: bootstrap with grant-without-ready, stray, early advance.
        fetch(16'h1234, 16'hBEEF, 3, 1'b1, 1'b1);
        fetch(16'hFFFF, 16'h0000, 0, 1'b0, 1'b0);
        fetch(16'h0000, 16'hFFFF, 5, 1'b1, 1'b0);
        for (int n = 0; n < 40; n++) begin
            fetch(AW'($urandom), DW'($urandom), int'($urandom % 5),
                  1'($urandom), 1'($urandom));
        end
        // Final advance brings the last returned word into execution.
        adv_i = 1'b1;
        tick();
        adv_i = 1'b0;
        chk("R9 last word executed", cir_o, exp_nir);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule